// File: doc/BRIEF.md
# Byte-Wide SPI Master With Register Bus

This block is an SPI master that a processor drives through a small synchronous byte bus. Software sets the clock polarity, the clock phase and a serial clock rate. It selects a slave by writing a one-hot pattern to the select register, then writes bytes to the data register. Each written byte goes into a transmit queue. The shift engine takes bytes from that queue one at a time and exchanges eight bits with the slave, most significant bit first. The byte that arrives on the input line is stored in a receive queue.

Software learns that a received byte is waiting by polling a status bit that stays high while the receive queue is empty. Reading the data register then returns that byte and removes it from the queue. Both queues are shallow, so software can post several bytes back to back. The shift engine stops and waits whenever the receive queue has no room left. No received byte is ever lost.

The serial clock rate comes from a 4-bit code. Two bits of it sit in the control register and two in the extension register. The mapping from code to divisor is a fixed table, and that table is not monotonic.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the status register reads 0x05, the select outputs are 0 and the serial clock is 0.
- R2: The rate code is {extension[1:0], control[1:0]}. The serial clock period is the following number of system clocks: 0000=2, 0001=4, 0100=8, 0010=16, 0011=32, 0101=64, 0110=128, 0111=256, 1000=512, 1001=1024, 1010=2048, 1011=4096. Each half period is half of that count.
- R3: Every accepted byte is shifted out on MOSI most significant bit first. At the same time eight MISO bits are captured, and the first captured bit becomes bit 7 of the received byte.
- R4: The clock rests at the level of control bit 3 (polarity) between transfers. When control bit 2 (phase) is 0, data is sampled on the first clock edge of each bit. When it is 1, data is sampled on the second edge. All four combinations transfer correctly.
- R5: Status bit 0 reads 1 while no received byte is waiting and reads 0 once one is.
- R6: A read of the data register (address 2) returns the oldest received byte and removes it. A read while the receive queue is empty returns the byte that the previous data read returned.
- R7: The transmit queue holds FIFO_DEPTH (default 4) bytes. Status bit 2 reports that it is empty and bit 3 that it is full. A data write while it is full is dropped.
- R8: While control bit 6 (enable) is 0, the clock rests at the polarity level, no transfer starts and data writes are dropped.
- R9: The select register (address 3) drives the select outputs directly and reads back the written value. The outputs change only after a write to that address.
- R10: The register addresses are control=0, status=1, data=2, select=3 and extension=4. Control reads back only bits 6, 3, 2, 1 and 0. Extension reads back only bits 1:0. All other status bits read 0.
- R11: The receive queue holds FIFO_DEPTH bytes. While it is full, no new transfer starts, so no received byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| sel | output | SEL_W | One-hot slave select, straight from the select register |

## Verification
Read data appears one cycle after the read strobe. The bench therefore drives each strobe on a falling edge and samples the result on the next falling edge.

The first serial clock edge comes one half period after the engine takes a byte, and each later edge follows one half period after the previous one. The bench measures the half period as the number of system cycles between the first and second edges, and compares it with half of the divisor for the code under test.

A received byte shows up in status bit 0 about two cycles after the sixteenth clock edge. For that reason the bench polls status instead of waiting a fixed time. The slave model acts on falling system edges, half a cycle after each serial clock edge, so both sides always see settled data.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int BYTE_W       = 8;
  localparam int ADDR_W       = 3;
  localparam int HALF_EXP_MAX = 11;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd2;
  localparam logic [ADDR_W-1:0] A_SEL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EXT  = 3'd4;

  localparam int CTL_EN  = 6;
  localparam int CTL_POL = 3;
  localparam int CTL_PHA = 2;

  localparam int ST_RXE = 0;
  localparam int ST_TXE = 2;
  localparam int ST_TXF = 3;

  // log2 of the half period in system clocks for a 4-bit rate code
  function automatic logic [3:0] half_exp(input logic [3:0] code);
    logic [3:0] e;
    case (code)
      4'b0000: e = 4'd0;
      4'b0001: e = 4'd1;
      4'b0100: e = 4'd2;
      4'b0010: e = 4'd3;
      4'b0011: e = 4'd4;
      4'b0101: e = 4'd5;
      4'b0110: e = 4'd6;
      4'b0111: e = 4'd7;
      4'b1000: e = 4'd8;
      4'b1001: e = 4'd9;
      4'b1010: e = 4'd10;
      default: e = 4'd11;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/spim_rate.sv
module spim_rate #(
  parameter int CW = spim_pkg::HALF_EXP_MAX
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic [3:0]    sh;

  always_comb begin
    sh  = spim_pkg::half_exp(code);
    lim = CW'((1 << sh) - 1);
  end

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W  = 8,
  localparam int EW = $clog2(2 * W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         spe,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         tick,
  input  logic         miso,
  input  logic         tx_avail,
  input  logic         rx_room,
  input  logic [W-1:0] tx_data,
  output logic         tx_take,
  output logic         busy,
  output logic         sck,
  output logic         mosi,
  output logic         rx_push,
  output logic [W-1:0] rx_data
);

  logic [W-1:0]  sreg;
  logic [EW-1:0] edge_i;
  logic          latch;
  logic          last_edge, samp_edge;

  assign tx_take   = spe && !busy && tx_avail && rx_room && !rx_push;
  assign last_edge = (edge_i == EW'(2 * W - 1));
  assign samp_edge = (edge_i[0] == cpha);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      sreg    <= '0;
      edge_i  <= '0;
      latch   <= 1'b0;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      rx_push <= 1'b0;
      if (!spe) begin
        busy <= 1'b0;
        sck  <= cpol;
      end else if (!busy) begin
        sck <= cpol;
        if (tx_take) begin
          busy   <= 1'b1;
          sreg   <= tx_data;
          mosi   <= tx_data[W-1];
          edge_i <= '0;
        end
      end else if (tick) begin
        sck    <= ~sck;
        edge_i <= edge_i + 1'b1;
        if (last_edge) begin
          busy    <= 1'b0;
          rx_push <= 1'b1;
          rx_data <= {sreg[W-2:0], cpha ? miso : latch};
        end else if (samp_edge) begin
          latch <= miso;
        end else if (edge_i != '0) begin
          sreg <= {sreg[W-2:0], latch};
          mosi <= sreg[W-2];
        end
      end
    end
  end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int FIFO_DEPTH = 4,
  parameter int SEL_W      = 4,
  localparam int BW        = spim_pkg::BYTE_W,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [spim_pkg::ADDR_W-1:0] reg_addr,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [BW-1:0]               reg_wdata,
  output logic [BW-1:0]               reg_rdata,
  output logic                        sck,
  output logic                        mosi,
  input  logic                        miso,
  output logic [SEL_W-1:0]            sel
);
  import spim_pkg::*;

  logic             spe_q, cpol_q, cpha_q;
  logic [1:0]       rate_q, ext_q;
  logic [SEL_W-1:0] sel_q;
  logic [BW-1:0]    last_q, rd_mux;

  logic          tx_push, tx_take, tx_empty, tx_full;
  logic [BW-1:0] tx_dout;
  logic [LW-1:0] tx_level;
  logic          rx_pop, rx_push, rx_empty, rx_full;
  logic [BW-1:0] rx_dout, rx_byte;
  logic [LW-1:0] rx_level;
  logic          shf_busy, tick;

  assign tx_push = reg_wr && (reg_addr == A_DATA) && spe_q && !tx_full;
  assign rx_pop  = reg_rd && (reg_addr == A_DATA) && !rx_empty;
  assign sel     = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      spe_q  <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      rate_q <= '0;
      ext_q  <= '0;
      sel_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          spe_q  <= reg_wdata[CTL_EN];
          cpol_q <= reg_wdata[CTL_POL];
          cpha_q <= reg_wdata[CTL_PHA];
          rate_q <= reg_wdata[1:0];
        end
        A_SEL:   sel_q <= reg_wdata[SEL_W-1:0];
        A_EXT:   ext_q <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[CTL_EN]  = spe_q;
        rd_mux[CTL_POL] = cpol_q;
        rd_mux[CTL_PHA] = cpha_q;
        rd_mux[1:0]     = rate_q;
      end
      A_STAT: begin
        rd_mux[ST_RXE] = rx_empty;
        rd_mux[ST_TXE] = tx_empty;
        rd_mux[ST_TXF] = tx_full;
      end
      A_DATA:  rd_mux = rx_empty ? last_q : rx_dout;
      A_SEL:   rd_mux = BW'(sel_q);
      A_EXT:   rd_mux[1:0] = ext_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      last_q    <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
      if (rx_pop) last_q <= rx_dout;
    end
  end

  spim_fifo #(.W(BW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .din(reg_wdata), .pop(tx_take),
    .dout(tx_dout), .empty(tx_empty), .full(tx_full), .level(tx_level)
  );

  spim_fifo #(.W(BW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte), .pop(rx_pop),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full), .level(rx_level)
  );

  spim_rate #(.CW(HALF_EXP_MAX)) u_rate (
    .clk(clk), .rst(rst), .run(shf_busy), .code({ext_q, rate_q}), .tick(tick)
  );

  spim_shift #(.W(BW)) u_shift (
    .clk(clk), .rst(rst), .spe(spe_q), .cpol(cpol_q), .cpha(cpha_q),
    .tick(tick), .miso(miso), .tx_avail(!tx_empty), .rx_room(!rx_full),
    .tx_data(tx_dout), .tx_take(tx_take), .busy(shf_busy), .sck(sck),
    .mosi(mosi), .rx_push(rx_push), .rx_data(rx_byte)
  );

endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int DEPTH = 4,
  parameter int SEL_W = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        reg_wr,
  input logic [spim_pkg::ADDR_W-1:0] reg_addr,
  input logic                        spe,
  input logic                        cpol,
  input logic                        busy,
  input logic                        sck,
  input logic [SEL_W-1:0]            sel,
  input logic [LW-1:0]               tx_level,
  input logic                        tx_pop,
  input logic                        tx_full,
  input logic                        rx_empty,
  input logic                        rx_push,
  input logic [LW-1:0]               rx_level
);

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && (cpol == $past(cpol))) |-> (sck == cpol));

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr && (reg_addr == spim_pkg::A_SEL)) |-> $stable(sel));

  // R8
  off_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == spim_pkg::A_DATA) && !spe) |=> $stable(tx_level));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_full && !tx_pop) |=> tx_full);

  // R5
  rx_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_empty) |-> $past(rx_push));

  // R11
  rx_room_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> (rx_level < LW'(DEPTH)));

endmodule

bind spi_byte_master spim_chk #(.DEPTH(FIFO_DEPTH), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .spe(spe_q),
  .cpol(cpol_q), .busy(shf_busy), .sck(sck), .sel(sel), .tx_level(tx_level),
  .tx_pop(tx_take), .tx_full(tx_full), .rx_empty(rx_empty),
  .rx_push(rx_push), .rx_level(rx_level)
);

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sck, mosi;
  logic       miso = 1'b0;
  logic [3:0] sel;

  int total = 0;
  int bad = 0;
  longint cyc = 0;

  logic [7:0] exp_rx[$];
  logic [7:0] exp_mosi[$];
  logic [7:0] slave_q[$];
  bit cpol_m = 1'b0;
  bit cpha_m = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_byte_master i_spi_byte_master (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .sel(sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  // driver: pushes expectations, then posts the byte
  task automatic send(input logic [7:0] tx, input logic [7:0] sl, input bit accept);
    if (accept) begin
      exp_rx.push_back(sl);
      exp_mosi.push_back(tx);
      slave_q.push_back(sl);
    end
    wr(3'd2, tx);
  endtask

  task automatic get_check(input string req);
    logic [7:0] v;
    int n;
    n = 0;
    rd(3'd1, v);
    while (v[0] && n < 40000) begin rd(3'd1, v); n++; end
    rd(3'd2, v);
    if (exp_rx.size() > 0) chk(req, v, exp_rx.pop_front());
    else chk(req, 32'hdead, 32'h0);
  endtask

  task automatic set_mode(input bit pol, input bit pha, input logic [3:0] code);
    wr(3'd3, 8'h00);
    cpol_m = pol; cpha_m = pha;
    wr(3'd4, {6'b0, code[3:2]});
    wr(3'd0, {1'b0, 1'b1, 2'b00, pol, pha, code[1:0]});
    wr(3'd3, 8'h01);
  endtask

  task automatic measure(output int h);
    longint t1;
    while (sck !== 1'b1) @(negedge clk);
    t1 = cyc;
    while (sck !== 1'b0) @(negedge clk);
    h = int'(cyc - t1);
  endtask

  // slave monitor: serves MISO bits and checks MOSI bytes (R3, R4)
  int s_edge = 0;
  logic s_prev = 1'b0;
  logic [7:0] s_out = '0;
  logic [7:0] s_in = '0;
  always @(negedge clk) begin
    if (rst || !sel[0]) begin
      s_edge = 0;
      s_prev = sck;
      miso = (slave_q.size() > 0) ? slave_q[0][7] : 1'b0;
    end else if (sck !== s_prev) begin
      s_prev = sck;
      if (s_edge == 0) s_out = (slave_q.size() > 0) ? slave_q[0] : 8'h00;
      if ((s_edge % 2) == int'(cpha_m)) begin
        s_in = {s_in[6:0], mosi};
      end else if (cpha_m) begin
        miso = s_out[7];
        s_out = s_out << 1;
      end else begin
        s_out = s_out << 1;
        miso = s_out[7];
      end
      s_edge++;
      if (s_edge == 16) begin
        s_edge = 0;
        if (exp_mosi.size() > 0) chk("R3 mosi byte", s_in, exp_mosi.pop_front());
        else chk("R3 unexpected byte", 32'hbad, 32'h0);
        if (slave_q.size() > 0) void'(slave_q.pop_front());
      end
    end else if (s_edge == 0 && !cpha_m) begin
      miso = (slave_q.size() > 0) ? slave_q[0][7] : 1'b0;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int exp_half[12] = '{1, 2, 8, 16, 4, 32, 64, 128, 256, 512, 1024, 2048};

  initial begin
    logic [7:0] v;
    int h;
    bit ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd1, v);
    chk("R1 status", v, 8'h05);
    chk("R1 sel", sel, 4'h0);
    chk("R1 sck", sck, 1'b0);

    // R9 select register
    wr(3'd3, 8'h04);
    chk("R9 sel out", sel, 4'h4);
    rd(3'd3, v);
    chk("R9 sel read", v, 8'h04);
    wr(3'd3, 8'h00);
    chk("R9 sel clear", sel, 4'h0);

    // R10 register map and read masks
    wr(3'd0, 8'hFF);
    rd(3'd0, v);
    chk("R10 ctrl read", v, 8'h4F);
    wr(3'd4, 8'hFF);
    rd(3'd4, v);
    chk("R10 ext read", v, 8'h03);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00);

    // R3 R4 all four clock modes
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0], 4'b0001);
      send(8'h96 ^ 8'(m), 8'h5B + 8'(m), 1'b1);
      send(8'h01 << m, 8'h80 >> m, 1'b1);
      rd(3'd1, v);
      chk("R5 empty while busy", v[0], 1'b1);
      get_check("R3 rx first");
      get_check("R4 rx second");
      @(negedge clk);
      chk("R4 idle level", sck, m[1]);
    end

    // R2 divider sweep
    for (int c = 0; c < 12; c++) begin
      set_mode(1'b0, 1'b0, 4'(c));
      send(8'hE7 ^ 8'(c), 8'h3C + 8'(c), 1'b1);
      measure(h);
      chk($sformatf("R2 half period code %0d", c), h, exp_half[c]);
      get_check("R2 rx byte");
    end

    // R7 R11 queue depth and stall
    set_mode(1'b0, 1'b0, 4'b0111);
    for (int i = 0; i < 5; i++) send(8'h10 + 8'(i), 8'hF0 - 8'(i), 1'b1);
    send(8'hAA, 8'h00, 1'b0);
    rd(3'd1, v);
    chk("R7 tx full flag", v, 8'h09);
    repeat (9000) @(negedge clk);
    rd(3'd1, v);
    chk("R11 stalled status", v, 8'h00);
    ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sck !== 1'b0) ok = 1'b0;
    end
    chk("R11 clock held while rx full", ok, 1'b1);
    for (int i = 0; i < 5; i++) get_check("R6 rx order");
    rd(3'd2, v);
    chk("R6 empty read repeats", v, 8'hEC);
    rd(3'd1, v);
    chk("R5 empty again", v, 8'h05);

    // R8 disabled block ignores data
    wr(3'd3, 8'h00);
    cpol_m = 1'b1;
    wr(3'd0, 8'h08);
    repeat (2) @(negedge clk);
    chk("R8 idle at polarity", sck, 1'b1);
    wr(3'd2, 8'h55);
    rd(3'd1, v);
    chk("R8 write dropped", v, 8'h05);
    wr(3'd0, 8'h48);
    ok = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sck !== 1'b1) ok = 1'b0;
    end
    chk("R8 no transfer after enable", ok, 1'b1);
    rd(3'd1, v);
    chk("R8 queues still empty", v, 8'h05);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule